// File: doc/BRIEF.md
# Shared-Bus Buffer Enable Controller

This block sits beside a secondary bus master that borrows one region of a primary master's bus. It watches the secondary master's active-low request and grant lines and drives the enables of the address/control buffer and the data buffer that join the two buses. The enable turns on when a grant is seen during a request. It then stays on for the whole request, even if the primary master withdraws the grant in the middle.

A mode input can require the shared-region chip-select as well before the buffers open. The block also gives the primary master a delayed copy of the request. The primary master therefore sees the request drop a fixed number of cycles after the buffers have closed, so the buffers are off before the primary master's next cycle begins. The delay is a parameter, `DELAY`, from 0 to 7 clock cycles.

Top module: `shbuf_ctrl`

## Requirements
- R1: At a rising clock edge where `req_n` and `gnt_n` are both low (and, in chip-select mode, `cs_n` is low too), `abuf_en` is high right after that edge.
- R2: While `abuf_en` is high and `req_n` stays low at each edge, `abuf_en` stays high whatever `gnt_n` does.
- R3: At a rising edge where `req_n` is high, `abuf_en` goes low right after that edge.
- R4: `abuf_en` does not turn on at an edge where `gnt_n` is high or `req_n` is high.
- R5: With `use_cs` high, `abuf_en` does not turn on at an edge where `cs_n` is high. With `use_cs` low, `cs_n` has no effect. Once the buffer is on, `cs_n` does not turn it off.
- R6: `dbuf_en` always equals `abuf_en`.
- R7: `dbuf_dir` equals `rd_wr` (1 = read, data flowing toward the secondary master) while `dbuf_en` is high, and is 0 while `dbuf_en` is low.
- R8: `fwd_req_n` equals the value `req_n` had `DELAY` rising edges earlier, on both its falling and its rising edges. With `DELAY` = 0 it follows `req_n` without delay.
- R9: While `rst_n` is low, `abuf_en`, `dbuf_en` and `dbuf_dir` are 0 and the whole delay line holds 1. `fwd_req_n` therefore reads 1 for `DELAY` edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_n | input | 1 | Secondary master bus request, active low |
| gnt_n | input | 1 | Grant from primary master, active low |
| cs_n | input | 1 | Shared-region chip-select, active low |
| use_cs | input | 1 | 1 = the chip-select must also be low to open the buffers |
| rd_wr | input | 1 | Transfer direction, 1 = read |
| abuf_en | output | 1 | Address/control buffer enable |
| dbuf_en | output | 1 | Data buffer enable |
| dbuf_dir | output | 1 | Data buffer direction, 1 = toward the secondary master |
| fwd_req_n | output | 1 | Delayed request to the primary master |

## Verification
The bench plays a normal request/grant handshake and a grant that is withdrawn mid-request; together these separate a latching enable from one that simply follows the grant. It also drives a grant with no request and a request with no grant, which catch enables that decode only one of the two lines. Chip-select mode runs with the select high and then low, and once more with plain mode, to show that the qualifier applies only when selected. Request pulses of one cycle and of several cycles pass through the delay line, so a wrong length or a missing edge shows up in `fwd_req_n` right after reset and on both edges of the request.

// File: rtl/shbuf_ctrl.sv
module shbuf_ctrl #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic gnt_n,
  input  logic cs_n,
  input  logic use_cs,
  input  logic rd_wr,
  output logic abuf_en,
  output logic dbuf_en,
  output logic dbuf_dir,
  output logic fwd_req_n
);

  logic held;
  logic start_ok;

  assign start_ok = !req_n && !gnt_n && (!use_cs || !cs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= !req_n && (held || start_ok);
  end

  assign abuf_en  = held;
  assign dbuf_en  = held;
  assign dbuf_dir = held & rd_wr;

  generate
    if (DELAY == 0) begin : g_nodly
      assign fwd_req_n = req_n;
    end else begin : g_dly
      logic [DELAY-1:0] line;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line <= '1;
        else begin
          line[0] <= req_n;
          for (int i = 1; i < int'(DELAY); i++) line[i] <= line[i-1];
        end
      end
      assign fwd_req_n = line[DELAY-1];
    end
  endgenerate

  // R1
  turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_n && !gnt_n && (!use_cs || !cs_n)) |=> abuf_en);

  // R2
  hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abuf_en && !req_n) |=> abuf_en);

  // R3
  turn_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_n |=> !abuf_en);

  // R4
  no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abuf_en && gnt_n) |=> !abuf_en);

  // R5
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!abuf_en && use_cs && cs_n) |=> !abuf_en);

endmodule

// File: tb/shbuf_ctrl_tb.sv
module shbuf_ctrl_tb_top;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, gnt_n = 1'b1, cs_n = 1'b1, use_cs = 1'b0, rd_wr = 1'b0;
  logic abuf_en, dbuf_en, dbuf_dir, fwd_req_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  string tag = "R9";

  bit m_held = 1'b0;
  bit q[$];

  always #2 clk = ~clk;

  shbuf_ctrl #(.DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .gnt_n(gnt_n), .cs_n(cs_n),
    .use_cs(use_cs), .rd_wr(rd_wr), .abuf_en(abuf_en), .dbuf_en(dbuf_en),
    .dbuf_dir(dbuf_dir), .fwd_req_n(fwd_req_n)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_held = 1'b0;
      q.delete();
      for (int i = 0; i < DLY; i++) q.push_back(1'b1);
    end else begin
      m_held = !req_n && (m_held || (!gnt_n && (!use_cs || !cs_n)));
      if (DLY > 0) begin
        q.push_back(req_n);
        void'(q.pop_front());
      end
    end
  end

  task automatic check(string t, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", t, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    logic ef;
    cyc++;
    ef = (DLY == 0) ? req_n : q[0];
    check(tag, "abuf_en", abuf_en, m_held);
    check(rst_n ? "R6" : "R9", "dbuf_en", dbuf_en, m_held);
    check(rst_n ? "R7" : "R9", "dbuf_dir", dbuf_dir, m_held & rd_wr);
    check(rst_n ? "R8" : "R9", "fwd_req_n", fwd_req_n, ef);
    if (cyc > 100000) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic drive(string t, logic rq, logic gn, logic cs, logic uc, logic rw, int n);
    @(negedge clk);
    #1;
    tag = t; req_n = rq; gnt_n = gn; cs_n = cs; use_cs = uc; rd_wr = rw;
    repeat (n - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R9: reset contents of the delay line observed right after release
    drive("R9", 1, 1, 1, 0, 0, 2);
    // R1 plain handshake, read direction (R7)
    drive("R4", 0, 1, 1, 0, 1, 3);
    drive("R1", 0, 0, 1, 0, 1, 3);
    // R2 grant withdrawn during request
    drive("R2", 0, 1, 1, 0, 1, 4);
    drive("R2", 0, 0, 1, 0, 0, 2);
    // R3 request dropped
    drive("R3", 1, 0, 1, 0, 0, 3);
    // R4 grant without request
    drive("R4", 1, 0, 1, 0, 0, 3);
    drive("R4", 1, 1, 1, 0, 0, 5);
    // R5 chip-select mode, select high then low
    drive("R5", 0, 0, 1, 1, 0, 4);
    drive("R5", 0, 0, 0, 1, 1, 3);
    drive("R5", 0, 1, 1, 1, 1, 3);
    drive("R3", 1, 1, 1, 1, 0, 3);
    // R5 plain mode ignores select
    drive("R5", 0, 0, 1, 0, 0, 3);
    drive("R3", 1, 1, 1, 0, 0, 6);
    // R8 short pulses through the delay line
    drive("R8", 0, 1, 1, 0, 0, 1);
    drive("R8", 1, 1, 1, 0, 0, 1);
    drive("R8", 0, 0, 1, 0, 1, 1);
    drive("R3", 1, 0, 1, 0, 1, 2);
    drive("R8", 0, 0, 1, 0, 0, 2);
    drive("R8", 1, 1, 1, 0, 0, 6);
    // R9 reset in the middle of an enabled transfer
    drive("R1", 0, 0, 1, 0, 1, 3);
    @(negedge clk);
    #1 rst_n = 1'b0; tag = "R9";
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    drive("R9", 1, 1, 1, 0, 0, 6);
    @(negedge clk);
    #1 finish_run();
  end
endmodule